// File: doc/BRIEF.md
# Global Status Byte and Error Flag Aggregator

This block keeps the eight-bit status byte that a serial register interface places at the head of every reply frame. Fault events from the rest of the chip (fail-safe entry, two device-specific faults, temperature pre-warning and thermal shutdown or overload) are caught in sticky bits. The frame engine reports the outcome of each frame, which sets a communication-error bit and a "link good" bit. A single clear pulse from a read-and-clear command drops the caught faults.

The top bit of the byte is a global error flag. It is the OR of the failure bits and of a vector of device-specific status summaries. Three configuration mask bits can keep the pre-warning and the two device-specific bits out of that OR, but those bits still show in the byte. The same flag drives the enable of an open-drain fault line, so that several devices can share one pull-up. All outputs are registered. Fault sources that a product does not have are switched off by a parameter and then always read 0.

Top module: `gstat_aggregator`

## Requirements
- R1: Byte layout: bit 7 error flag, bit 6 communication error, bit 5 link good (active low failure), bit 4 thermal/overload, bit 3 pre-warning, bit 2 device fault B, bit 1 device fault A, bit 0 fail-safe; `fault_evt[k]` feeds bit k for k = 0..4.
- R2: An enabled fault event sets its bit on the next clock edge, and the bit stays 1 with no further event until a clear.
- R3: A `clr_pulse` clears bits 6 and 4..0 on the next edge and leaves bit 5 unchanged.
- R4: A bit whose event is active in the same cycle as `clr_pulse` is 1 after that edge.
- R5: Bit 5 is 0 after reset. A `frame_ok` sets it to 1. A `frame_err` or `chip_rst_evt` sets it to 0, and this wins over `frame_ok` in the same cycle.
- R6: `frame_err` sets bit 6 on the next edge.
- R7: Bit 7 equals the OR of bits 6, 4 and 0, the inverse of bit 5, bit 3 unless `cfg_mask[2]`, bit 2 unless `cfg_mask[1]`, bit 1 unless `cfg_mask[0]`, and any bit of `dev_status`, all taken at the same edge. A masked bit still reads 1 in the byte.
- R8: `fault_pull_en` equals the error flag in every cycle.
- R9: A fault source whose `FEATURE_EN` bit is 0 reads 0 and never raises the flag.
- R10: After synchronous reset the byte reads 0x80 and `fault_pull_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fault_evt | input | 5 | Fault events for status bits 4..0 |
| frame_ok | input | 1 | One-cycle pulse: frame ended with correct length |
| frame_err | input | 1 | One-cycle pulse: frame ended with a communication error |
| chip_rst_evt | input | 1 | Registers of the device were returned to defaults |
| dev_status | input | NUM_EXT | Summaries of device-specific status registers |
| cfg_mask | input | 3 | Flag mask for status bits 3..1 (bit 0 of mask for status bit 1) |
| clr_pulse | input | 1 | Clear request from a read-and-clear command |
| status_byte | output | 8 | Global status byte |
| gef | output | 1 | Global error flag |
| fault_pull_en | output | 1 | Drive-low enable for the shared open-drain fault line |

## Verification
The bench builds the block with two device-specific status inputs and with device fault B switched off, so one parameter setting reaches both the always-zero path of an absent source and the mixing of external summaries into the flag. A behavioural model is compared with the outputs on every clock. Directed frames cover a clear colliding with an event, a mask that is changed while its bit is held, and a valid frame that coincides with an error frame. A pseudo-random phase then mixes all inputs.

// File: rtl/gstat_pkg.sv
package gstat_pkg;
  localparam int BIT_FAILSAFE = 0;
  localparam int BIT_DEV_A    = 1;
  localparam int BIT_DEV_B    = 2;
  localparam int BIT_PREWARN  = 3;
  localparam int BIT_THERMAL  = 4;
  localparam int BIT_LINK     = 5;
  localparam int BIT_COMMERR  = 6;
  localparam int BIT_FLAG     = 7;
  localparam int SENSED_W     = 5;
  localparam int LATCH_W      = 7;
  localparam int MASK_W       = 3;
  localparam int MASK_LO      = BIT_DEV_A;
endpackage

// File: rtl/gstat_sticky.sv
module gstat_sticky #(
  parameter bit ENABLE = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic evt,
  input  logic clr,
  output logic q,
  output logic q_nxt
);
  logic evt_g;
  assign evt_g = ENABLE ? evt : 1'b0;

  always_comb begin
    if (evt_g)    q_nxt = 1'b1;
    else if (clr) q_nxt = 1'b0;
    else          q_nxt = q;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= q_nxt;
  end

  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (rst) (evt_g |=> q)); // R2
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst) (clr && !evt_g |=> !q)); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) (!evt_g && !clr |=> $stable(q))); // R2
endmodule

// File: rtl/gstat_link.sv
module gstat_link (
  input  logic clk,
  input  logic rst,
  input  logic good,
  input  logic bad,
  output logic q,
  output logic q_nxt
);
  always_comb begin
    if (bad)       q_nxt = 1'b0;
    else if (good) q_nxt = 1'b1;
    else           q_nxt = q;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= q_nxt;
  end

  AST_BAD_DROPS: assert property (@(posedge clk) disable iff (rst) (bad |=> !q)); // R5
  AST_GOOD_SETS: assert property (@(posedge clk) disable iff (rst) (good && !bad |=> q)); // R5
endmodule

// File: rtl/gstat_flag.sv
module gstat_flag
  import gstat_pkg::*;
#(
  parameter int NUM_EXT = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [LATCH_W-1:0]  lat_nxt,
  input  logic [MASK_W-1:0]   cfg_mask,
  input  logic [NUM_EXT-1:0]  ext,
  output logic                flag_q
);
  logic [LATCH_W-1:0] contrib;
  logic               flag_d;

  always_comb begin
    contrib = lat_nxt;
    contrib[BIT_LINK] = ~lat_nxt[BIT_LINK];
    for (int k = 0; k < MASK_W; k++) begin
      if (cfg_mask[k]) contrib[MASK_LO + k] = 1'b0;
    end
    flag_d = (|contrib) | (|ext);
  end

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b1;
    else     flag_q <= flag_d;
  end

  AST_UNMASKABLE: assert property (@(posedge clk) disable iff (rst)
    (lat_nxt[BIT_COMMERR] || lat_nxt[BIT_THERMAL] || lat_nxt[BIT_FAILSAFE] || (|ext) |=> flag_q)); // R7
endmodule

// File: rtl/gstat_aggregator.sv
module gstat_aggregator
  import gstat_pkg::*;
#(
  parameter int                NUM_EXT    = 4,
  parameter logic [SENSED_W-1:0] FEATURE_EN = '1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SENSED_W-1:0] fault_evt,
  input  logic                frame_ok,
  input  logic                frame_err,
  input  logic                chip_rst_evt,
  input  logic [NUM_EXT-1:0]  dev_status,
  input  logic [MASK_W-1:0]   cfg_mask,
  input  logic                clr_pulse,
  output logic [7:0]          status_byte,
  output logic                gef,
  output logic                fault_pull_en
);
  logic [LATCH_W-1:0] lat_q;
  logic [LATCH_W-1:0] lat_nxt;
  logic               flag_q;

  for (genvar i = 0; i < SENSED_W; i++) begin : g_sensed
    gstat_sticky #(.ENABLE(FEATURE_EN[i])) u_bit (
      .clk(clk), .rst(rst), .evt(fault_evt[i]), .clr(clr_pulse),
      .q(lat_q[i]), .q_nxt(lat_nxt[i])
    );
  end

  gstat_sticky #(.ENABLE(1'b1)) u_commerr (
    .clk(clk), .rst(rst), .evt(frame_err), .clr(clr_pulse),
    .q(lat_q[BIT_COMMERR]), .q_nxt(lat_nxt[BIT_COMMERR])
  );

  gstat_link u_link (
    .clk(clk), .rst(rst), .good(frame_ok), .bad(frame_err | chip_rst_evt),
    .q(lat_q[BIT_LINK]), .q_nxt(lat_nxt[BIT_LINK])
  );

  gstat_flag #(.NUM_EXT(NUM_EXT)) u_flag (
    .clk(clk), .rst(rst), .lat_nxt(lat_nxt), .cfg_mask(cfg_mask),
    .ext(dev_status), .flag_q(flag_q)
  );

  assign status_byte   = {flag_q, lat_q};
  assign gef           = flag_q;
  assign fault_pull_en = flag_q;

  AST_ERR_MARKS: assert property (@(posedge clk) disable iff (rst)
    (frame_err |=> status_byte[BIT_COMMERR] && !status_byte[BIT_LINK])); // R6
  AST_LINK_RAISES_FLAG: assert property (@(posedge clk) disable iff (rst)
    (!status_byte[BIT_LINK] |-> status_byte[BIT_FLAG])); // R7
endmodule

// File: tb/sim_gstat_aggregator.sv
module sim_gstat_aggregator;
  localparam int NUM_EXT = 2;
  localparam logic [4:0] FEAT = 5'b11011;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0] fault_evt = '0;
  logic frame_ok = 1'b0, frame_err = 1'b0, chip_rst_evt = 1'b0, clr_pulse = 1'b0;
  logic [NUM_EXT-1:0] dev_status = '0;
  logic [2:0] cfg_mask = '0;
  logic [7:0] status_byte;
  logic gef, fault_pull_en;

  int vectors = 0;
  int errors  = 0;
  logic [6:0] m_lat = '0;
  logic       m_gef = 1'b1;

  always #4 clk = ~clk;

  gstat_aggregator #(.NUM_EXT(NUM_EXT), .FEATURE_EN(FEAT)) u0 (
    .clk(clk), .rst(rst), .fault_evt(fault_evt), .frame_ok(frame_ok),
    .frame_err(frame_err), .chip_rst_evt(chip_rst_evt), .dev_status(dev_status),
    .cfg_mask(cfg_mask), .clr_pulse(clr_pulse), .status_byte(status_byte),
    .gef(gef), .fault_pull_en(fault_pull_en)
  );

  // Reference model, updated on every rising edge
  always @(posedge clk) begin
    if (rst) begin
      m_lat = '0;
      m_gef = 1'b1;
    end else begin
      for (int i = 0; i < 5; i++) begin
        if (FEAT[i] && fault_evt[i]) m_lat[i] = 1'b1;
        else if (clr_pulse)          m_lat[i] = 1'b0;
      end
      if (frame_err)      m_lat[6] = 1'b1;
      else if (clr_pulse) m_lat[6] = 1'b0;
      if (frame_err || chip_rst_evt) m_lat[5] = 1'b0;
      else if (frame_ok)             m_lat[5] = 1'b1;
      m_gef = m_lat[6] | m_lat[4] | m_lat[0] | !m_lat[5]
            | (m_lat[3] & !cfg_mask[2]) | (m_lat[2] & !cfg_mask[1])
            | (m_lat[1] & !cfg_mask[0]) | (|dev_status);
    end
  end

  // Per-cycle comparison, away from the rising edge
  always @(negedge clk) begin
    if (!rst) begin
      vectors++;
      if (status_byte[4:0] !== m_lat[4:0]) begin
        errors++;
        $display("FAIL R2 fault bits: got %b exp %b", status_byte[4:0], m_lat[4:0]);
      end
      if (status_byte[5] !== m_lat[5]) begin
        errors++;
        $display("FAIL R5 link bit: got %b exp %b", status_byte[5], m_lat[5]);
      end
      if (status_byte[6] !== m_lat[6]) begin
        errors++;
        $display("FAIL R6 comm error bit: got %b exp %b", status_byte[6], m_lat[6]);
      end
      if (status_byte[7] !== m_gef || gef !== m_gef) begin
        errors++;
        $display("FAIL R7 flag: got %b/%b exp %b", status_byte[7], gef, m_gef);
      end
      if (fault_pull_en !== m_gef) begin
        errors++;
        $display("FAIL R8 pull enable: got %b exp %b", fault_pull_en, m_gef);
      end
    end
  end

  task automatic chk(input logic [7:0] exp, input string tag);
    vectors++;
    if (status_byte !== exp || fault_pull_en !== exp[7]) begin
      errors++;
      $display("FAIL %s: got byte %h pull %b exp byte %h pull %b",
               tag, status_byte, fault_pull_en, exp, exp[7]);
    end
  endtask

  task automatic idle();
    fault_evt = '0; frame_ok = 0; frame_err = 0; chip_rst_evt = 0; clr_pulse = 0;
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(8'h80, "R10 reset state");
    frame_ok = 1; step();
    chk(8'h20, "R5 valid frame sets link");
    fault_evt[4] = 1; step();
    chk(8'hB0, "R1 R2 thermal at bit 4");
    repeat (3) step();
    chk(8'hB0, "R2 held without event");
    clr_pulse = 1; step();
    chk(8'h20, "R3 clear keeps link bit");
    cfg_mask = 3'b100; fault_evt[3] = 1; step();
    chk(8'h28, "R7 masked pre-warning visible, flag low");
    cfg_mask = 3'b000; step();
    step();
    chk(8'hA8, "R7 unmasked pre-warning raises flag");
    clr_pulse = 1; step();
    chk(8'h20, "R3 clear after pre-warning");
    fault_evt[2] = 1; step();
    chk(8'h20, "R9 absent source reads zero");
    fault_evt[0] = 1; clr_pulse = 1; step();
    chk(8'hA1, "R4 event wins over clear");
    clr_pulse = 1; step();
    chk(8'h20, "R3 fail-safe cleared");
    dev_status = 2'b10; step();
    chk(8'hA0, "R7 device status summary raises flag");
    dev_status = 2'b00; step();
    chk(8'h20, "R7 device status released");
    frame_err = 1; step();
    chk(8'hC0, "R6 R5 comm error sets bit 6, drops link");
    frame_ok = 1; step();
    chk(8'hE0, "R5 valid frame restores link, bit 6 sticky");
    clr_pulse = 1; step();
    chk(8'h20, "R3 comm error cleared");
    chip_rst_evt = 1; step();
    chk(8'h80, "R5 chip reset drops link");
    frame_ok = 1; frame_err = 1; step();
    chk(8'hC0, "R5 error wins over valid frame");
    for (int n = 0; n < 600; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      fault_evt    = (lfsr[4:0] & {5{lfsr[9] & lfsr[11]}});
      frame_ok     = lfsr[5];
      frame_err    = lfsr[6] & lfsr[7] & lfsr[8];
      chip_rst_evt = lfsr[12] & lfsr[13] & lfsr[14] & lfsr[15];
      clr_pulse    = lfsr[10] & lfsr[3];
      cfg_mask     = lfsr[15:13];
      dev_status   = lfsr[2:1] & {NUM_EXT{lfsr[0] & lfsr[7]}};
      @(negedge clk);
    end
    idle();
    dev_status = '0;
    rst = 1'b1; step(); rst = 1'b0;
    chk(8'h80, "R10 reset after traffic");
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule